// File: doc/BRIEF.md
# Prioritised Interrupt Request Controller

This block collects interrupt requests from fourteen sources inside a 16-bit chipset and turns them into one 3-bit interrupt level for the CPU. It keeps a request register and an enable register. Software changes either register through a small bus port with set/clear writes. Data bit 15 of a write selects whether the other data bits set or clear the matching register bits. Hardware sources raise their request bits with single-cycle pulses. The vertical-blank source is not a pin. It comes from an internal line counter that raises its request when the frame wraps back to line zero.

Pending sources are those that are both requested and enabled, and they count only while the master-enable bit of the enable register is set. The pending sources fall into six priority groups. The registered level output carries the number of the highest group that has a pending source. While the CPU runs an interrupt-acknowledge cycle, the block raises an indication that the CPU should use autovectoring.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After synchronous reset, both registers read as zero, the level output is 0 and the line counter is at line 0.
- R2: A write with data bit 15 = 1 sets each register bit whose data bit is 1 and leaves the others unchanged. The enable register is written at byte offset 0x09A and the request register at offset 0x09C.
- R3: A write with data bit 15 = 0 clears each register bit whose data bit is 1 and leaves the others unchanged.
- R4: While the read strobe is high, offset 0x01C returns the enable register and offset 0x01E returns the request register, in the same cycle. Bit 15 of the enable readback and bits 15:14 of the request readback always read 0. Any other offset, or a cycle without the read strobe, returns 0.
- R5: A source is pending only when its request bit and its enable bit are both 1. No level other than 0 is output while enable bit 14 (the master enable) is 0.
- R6: The source bits map to levels as follows: bit 13 (external) gives 6; bits 11 (serial receive) and 12 (disk sync) give 5; bits 7 to 10 (audio 0 to 3) give 4; bits 4 (copper), 5 (vertical blank) and 6 (blitter) give 3; bit 3 (I/O ports and timers) gives 2; bits 0 (serial transmit), 1 (disk block) and 2 (software) give 1.
- R7: When sources from several groups are pending, the output is the highest of their levels. With nothing pending, the output is 0.
- R8: The level output is registered. It reflects the register contents one clock edge after they change.
- R9: A high bit of `src_pulse` sets the matching request bit at the next edge. This holds even when a clear write to the request register targets the same bit in that cycle.
- R10: The line counter advances once per `line_tick` and counts LINES lines per frame (312 by default). The tick that wraps it from line LINES-1 to line 0 sets request bit 5 at the same edge.
- R11: `autovec` is high in exactly the cycles in which `iack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 9 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one access per high cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data; bit 15 selects set (1) or clear (0) |
| bus_rdata | output | 16 | Read data, valid in the strobe cycle |
| src_pulse | input | 14 | Per-source request pulses |
| line_tick | input | 1 | One pulse per completed display line |
| iack | input | 1 | CPU interrupt-acknowledge cycle in progress |
| autovec | output | 1 | Autovector indication to the CPU |
| irq_level | output | 3 | Current CPU interrupt level, 0 = none |

## Verification
Register contents change at the edge that samples a write, a source pulse or the wrapping line tick. The bench therefore reads the registers at the falling edge that follows that edge, and readback is combinational. The level output lags the registers by one more edge. Each level check first confirms that the old level is still present at the first falling edge, and then expects the new value at the next one. The autovector indication and the readback mux need no clock edge, so they are sampled a fraction of a cycle after the inputs are driven.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NSRC   = 14;
    localparam int EN_W   = NSRC + 1;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 9;
    localparam int LVL_W  = 3;

    // Bit position of the master enable inside the enable register
    localparam int MASTER_BIT = NSRC;

    localparam logic [ADDR_W-1:0] OFS_EN_RD = 9'h01C;
    localparam logic [ADDR_W-1:0] OFS_RQ_RD = 9'h01E;
    localparam logic [ADDR_W-1:0] OFS_EN_WR = 9'h09A;
    localparam logic [ADDR_W-1:0] OFS_RQ_WR = 9'h09C;

    // Source bit positions
    localparam int SRC_SER_TX  = 0;
    localparam int SRC_DSK_BLK = 1;
    localparam int SRC_SOFT    = 2;
    localparam int SRC_PORTS   = 3;
    localparam int SRC_COPPER  = 4;
    localparam int SRC_VBLANK  = 5;
    localparam int SRC_BLIT    = 6;
    localparam int SRC_AUD0    = 7;
    localparam int SRC_AUD3    = 10;
    localparam int SRC_SER_RX  = 11;
    localparam int SRC_DSK_SYN = 12;
    localparam int SRC_EXT     = 13;

    typedef enum logic [LVL_W-1:0] {
        LVL_NONE = 3'd0,
        LVL_1    = 3'd1,
        LVL_2    = 3'd2,
        LVL_3    = 3'd3,
        LVL_4    = 3'd4,
        LVL_5    = 3'd5,
        LVL_6    = 3'd6
    } irq_lvl_e;

    typedef enum logic [1:0] {
        SC_IDLE  = 2'd0,
        SC_SET   = 2'd1,
        SC_CLEAR = 2'd2
    } sc_op_e;

    // Per-group occupancy vector; index = level - 1
    typedef struct packed {
        logic g6;
        logic g5;
        logic g4;
        logic g3;
        logic g2;
        logic g1;
    } grp_hits_t;

    function automatic grp_hits_t group_hits(input logic [NSRC-1:0] pend);
        grp_hits_t h;
        h.g6 = pend[SRC_EXT];
        h.g5 = pend[SRC_SER_RX] | pend[SRC_DSK_SYN];
        h.g4 = |pend[SRC_AUD3:SRC_AUD0];
        h.g3 = pend[SRC_COPPER] | pend[SRC_VBLANK] | pend[SRC_BLIT];
        h.g2 = pend[SRC_PORTS];
        h.g1 = pend[SRC_SER_TX] | pend[SRC_DSK_BLK] | pend[SRC_SOFT];
        return h;
    endfunction

    function automatic irq_lvl_e top_level(input grp_hits_t h);
        irq_lvl_e l;
        if (h.g6)      l = LVL_6;
        else if (h.g5) l = LVL_5;
        else if (h.g4) l = LVL_4;
        else if (h.g3) l = LVL_3;
        else if (h.g2) l = LVL_2;
        else if (h.g1) l = LVL_1;
        else           l = LVL_NONE;
        return l;
    endfunction

    function automatic sc_op_e decode_op(input logic wr, input logic hit,
                                         input logic polarity);
        if (!(wr && hit)) return SC_IDLE;
        return polarity ? SC_SET : SC_CLEAR;
    endfunction

endpackage

// File: rtl/irq_setclr_reg.sv
module irq_setclr_reg
    import irq_pkg::*;
#(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  sc_op_e       op,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] q
);

    // One flop per bit; a hardware set is applied after the software
    // action so that it overrides a simultaneous clear.
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic sw_next;
        always_comb begin
            unique case (op)
                SC_SET:   sw_next = q[i] | mask[i];
                SC_CLEAR: sw_next = q[i] & ~mask[i];
                default:  sw_next = q[i];
            endcase
        end
        always_ff @(posedge clk) begin
            if (rst) q[i] <= 1'b0;
            else     q[i] <= sw_next | hw_set[i];
        end
    end

endmodule

// File: rtl/irq_frame_timer.sv
module irq_frame_timer #(
    parameter int LINES = 312,
    localparam int CW = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_tick,
    output logic [CW-1:0] line_cnt,
    output logic          frame_wrap
);

    localparam logic [CW-1:0] LAST = CW'(LINES - 1);

    logic at_last;
    assign at_last    = (line_cnt == LAST);
    assign frame_wrap = line_tick && at_last;

    always_ff @(posedge clk) begin
        if (rst)             line_cnt <= '0;
        else if (frame_wrap) line_cnt <= '0;
        else if (line_tick)  line_cnt <= line_cnt + CW'(1);
    end

endmodule

// File: rtl/irq_level_enc.sv
module irq_level_enc
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] req,
    input  logic [EN_W-1:0] en,
    output irq_lvl_e        level
);

    logic [NSRC-1:0] pend;
    grp_hits_t       hits;
    irq_lvl_e        level_d;

    assign pend    = req & en[NSRC-1:0];
    assign hits    = group_hits(pend);
    assign level_d = en[MASTER_BIT] ? top_level(hits) : LVL_NONE;

    always_ff @(posedge clk) begin
        if (rst) level <= LVL_NONE;
        else     level <= level_d;
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int LINES = 312
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NSRC-1:0]      src_pulse,
    input  logic                 line_tick,
    input  logic                 iack,
    output logic                 autovec,
    output logic [LVL_W-1:0]     irq_level
);

    localparam int CW = (LINES > 1) ? $clog2(LINES) : 1;

    logic [NSRC-1:0] req_q;
    logic [EN_W-1:0] en_q;
    logic [NSRC-1:0] hw_req;
    logic [CW-1:0]   line_cnt;
    logic            frame_wrap;
    sc_op_e          en_op;
    sc_op_e          rq_op;
    irq_lvl_e        level;
    logic            polarity;

    assign polarity = bus_wdata[DATA_W-1];
    assign en_op    = decode_op(bus_wr, bus_addr == OFS_EN_WR, polarity);
    assign rq_op    = decode_op(bus_wr, bus_addr == OFS_RQ_WR, polarity);

    irq_frame_timer #(.LINES(LINES)) u_frame (
        .clk        (clk),
        .rst        (rst),
        .line_tick  (line_tick),
        .line_cnt   (line_cnt),
        .frame_wrap (frame_wrap)
    );

    always_comb begin
        hw_req             = src_pulse;
        hw_req[SRC_VBLANK] = src_pulse[SRC_VBLANK] | frame_wrap;
    end

    irq_setclr_reg #(.W(NSRC)) u_req (
        .clk    (clk),
        .rst    (rst),
        .op     (rq_op),
        .mask   (bus_wdata[NSRC-1:0]),
        .hw_set (hw_req),
        .q      (req_q)
    );

    irq_setclr_reg #(.W(EN_W)) u_en (
        .clk    (clk),
        .rst    (rst),
        .op     (en_op),
        .mask   (bus_wdata[EN_W-1:0]),
        .hw_set ('0),
        .q      (en_q)
    );

    irq_level_enc u_enc (
        .clk   (clk),
        .rst   (rst),
        .req   (req_q),
        .en    (en_q),
        .level (level)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == OFS_EN_RD)      bus_rdata[EN_W-1:0] = en_q;
            else if (bus_addr == OFS_RQ_RD) bus_rdata[NSRC-1:0] = req_q;
        end
    end

    assign irq_level = level;
    assign autovec   = iack;

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
    import irq_pkg::*;
#(
    parameter int LINES = 312,
    localparam int CW = (LINES > 1) ? $clog2(LINES) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NSRC-1:0]   src_pulse,
    input logic              line_tick,
    input logic [LVL_W-1:0]  irq_level,
    input logic [NSRC-1:0]   req_q,
    input logic [EN_W-1:0]   en_q,
    input logic [CW-1:0]     line_cnt
);

    a_r2_set_enable: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_EN_WR && bus_wdata[15])
        |=> ((en_q & $past(bus_wdata[EN_W-1:0])) == $past(bus_wdata[EN_W-1:0])));

    a_r3_clear_request: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_RQ_WR && !bus_wdata[15] && src_pulse == '0 && !line_tick)
        |=> ((req_q & $past(bus_wdata[NSRC-1:0])) == '0));

    a_r5_master_gate: assert property (@(posedge clk) disable iff (rst)
        !en_q[MASTER_BIT] |=> (irq_level == 3'd0));

    a_r6_level_range: assert property (@(posedge clk) disable iff (rst)
        irq_level <= 3'd6);

    a_r7_external_top: assert property (@(posedge clk) disable iff (rst)
        (en_q[MASTER_BIT] && en_q[SRC_EXT] && req_q[SRC_EXT]) |=> (irq_level == 3'd6));

    a_r9_pulse_sets: assert property (@(posedge clk) disable iff (rst)
        (src_pulse != '0) |=> ((req_q & $past(src_pulse)) == $past(src_pulse)));

    a_r10_line_bound: assert property (@(posedge clk) disable iff (rst)
        line_cnt < CW'(LINES));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.LINES(LINES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .src_pulse (src_pulse),
    .line_tick (line_tick),
    .irq_level (irq_level),
    .req_q     (req_q),
    .en_q      (en_q),
    .line_cnt  (line_cnt)
);

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;

    localparam int LINES = 312;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [8:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [13:0] src_pulse = '0;
    logic        line_tick = 1'b0;
    logic        iack = 1'b0;
    logic        autovec;
    logic [2:0]  irq_level;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    irq_prio_ctrl #(.LINES(LINES)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_pulse (src_pulse),
        .line_tick (line_tick),
        .iack      (iack),
        .autovec   (autovec),
        .irq_level (irq_level)
    );

    // Level table taken from the requirement text (R6)
    function automatic int lvl_of(input int b);
        if (b == 13)             return 6;
        if (b == 11 || b == 12)  return 5;
        if (b >= 7 && b <= 10)   return 4;
        if (b >= 4 && b <= 6)    return 3;
        if (b == 3)              return 2;
        return 1;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [15:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic tick();
        line_tick = 1'b1;
        step();
        line_tick = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 level", int'(irq_level), 0);
        rd(9'h01C, d); check("R1 enable", int'(d), 0);
        rd(9'h01E, d); check("R1 request", int'(d), 0);

        // R11 autovector follows acknowledge
        check("R11 idle", int'(autovec), 0);
        iack = 1'b1; #1 check("R11 ack", int'(autovec), 1);
        iack = 1'b0; #1 check("R11 release", int'(autovec), 0);

        // R4 unmapped offset and missing strobe
        wr(9'h09A, 16'hFFFF);
        rd(9'h09A, d); check("R4 unmapped", int'(d), 0);
        bus_addr = 9'h01C; #1 check("R4 no strobe", int'(bus_rdata), 0);

        // R2 / R4 set and readback of the enable register
        rd(9'h01C, d); check("R2 enable set", int'(d), 16'h7FFF);
        wr(9'h09A, 16'h0003);
        rd(9'h01C, d); check("R3 enable clear", int'(d), 16'h7FFC);
        wr(9'h09A, 16'h8003);
        rd(9'h01C, d); check("R2 enable reset bits", int'(d), 16'h7FFF);

        // R4 request readback masks bits 15:14
        wr(9'h09C, 16'hFFFF);
        rd(9'h01E, d); check("R4 request width", int'(d), 16'h3FFF);
        wr(9'h09C, 16'h0F00);
        rd(9'h01E, d); check("R3 request partial clear", int'(d), 16'h30FF);

        // R6 / R8 single-source sweep
        for (int i = 0; i < 14; i++) begin
            wr(9'h09C, 16'h3FFF);
            wr(9'h09C, 16'h8000 | (16'h1 << i));
            check("R8 level lags one edge", int'(irq_level), 0);
            rd(9'h01E, d); check("R2 request single", int'(d), 1 << i);
            step();
            check("R6 single source level", int'(irq_level), lvl_of(i));
        end

        // R7 pairwise sweep: highest level wins
        for (int i = 0; i < 14; i++) begin
            for (int j = 0; j < 14; j++) begin
                wr(9'h09C, 16'h3FFF);
                wr(9'h09C, 16'h8000 | (16'h1 << i) | (16'h1 << j));
                step();
                check("R7 pair level", int'(irq_level),
                      (lvl_of(i) > lvl_of(j)) ? lvl_of(i) : lvl_of(j));
            end
        end
        wr(9'h09C, 16'h3FFF);
        step();
        check("R7 nothing pending", int'(irq_level), 0);

        // R5 master enable and per-source mask
        wr(9'h09A, 16'h4000);
        wr(9'h09C, 16'hBFFF);
        step();
        check("R5 master off", int'(irq_level), 0);
        rd(9'h01E, d); check("R5 requests held", int'(d), 16'h3FFF);
        wr(9'h09A, 16'hC000);
        step();
        check("R5 master on", int'(irq_level), 6);
        wr(9'h09A, 16'h2000);
        step();
        check("R5 mask external", int'(irq_level), 5);
        wr(9'h09A, 16'h1800);
        step();
        check("R5 mask group five", int'(irq_level), 4);
        wr(9'h09A, 16'h3FFF);
        step();
        check("R5 no sources enabled", int'(irq_level), 0);
        wr(9'h09A, 16'hFFFF);

        // R9 pulse sets, and beats a simultaneous clear
        wr(9'h09C, 16'h3FFF);
        src_pulse = 14'h0800;
        step();
        src_pulse = '0;
        rd(9'h01E, d); check("R9 pulse sets", int'(d), 16'h0800);
        src_pulse = 14'h0004;
        wr(9'h09C, 16'h3FFF);
        src_pulse = '0;
        rd(9'h01E, d); check("R9 pulse over clear", int'(d), 16'h0004);

        // R10 vertical blank after a full frame of ticks, twice
        for (int f = 0; f < 2; f++) begin
            wr(9'h09C, 16'h3FFF);
            for (int k = 0; k < LINES - 1; k++) tick();
            rd(9'h01E, d); check("R10 before wrap", int'(d), 0);
            tick();
            rd(9'h01E, d); check("R10 wrap sets vblank", int'(d), 16'h0020);
            check("R10 level lags", int'(irq_level), 0);
            step();
            check("R10 vblank level", int'(irq_level), 3);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule